// File: doc/BRIEF.md
# Nibble-Wide DRAM Access Sequencer

This block lets a video fetcher and a CPU share one DRAM that is only four bits wide and takes its address multiplexed over a single bus. Every eight clock cycles the block runs one bus slot. In that slot it moves one whole byte as two nibble accesses. These two accesses share a row address and differ only in the least significant bit of the column.

At the start of each slot the block picks an owner. The slot goes to video when video asks for it and the inhibit input is low. In every other case the CPU gets the slot, and the CPU's read/write input gives the direction. The block then drives the row address and the row strobe, and after that two column addresses, each with its own column strobe pulse. On a read it joins the two nibbles into a byte and hands that byte to video or to the CPU. On a write it drives the high nibble of the CPU data during the first column access and the low nibble during the second.

The 16-bit byte address is split into a 9-bit row (the address shifted down by 7) and a 7-bit column. The column is shifted up by one bit, and a nibble select fills bit 0.

Top module: `nibble_dram_seq`

## Requirements
- R1: An 8-bit one-hot phase ring rotates left once per clock, so a bus slot lasts 8 cycles. Phase bit 0 is the slot start, and reset returns the ring to bit 0.
- R2: Slot ownership and the address, direction and write data are sampled only at the clock edge that ends a bit-0 cycle. Video owns the slot when vid_req=1 and vid_inhibit=0. Otherwise the CPU owns it, with cpu_rd=1 meaning read and 0 meaning write. Input changes later in the slot have no effect on that slot.
- R3: ram_addr carries the row (address >> 7, 9 bits) in the phase bit 1 and bit 2 cycles. row_strobe is low in the bit-1 cycle and high from bit 2 through bit 7 and the bit-0 cycle that follows.
- R4: ram_addr carries {address[6:0],0} in the bit 3, 4 and 5 cycles, and {address[6:0],1} in the bit 6, 7 and following bit-0 cycles. col_strobe is high only in the bit 4, 5, 7 and 0 cycles.
- R5: A read byte takes bits 7:4 from the ram_rdata value sampled at the end of the bit-5 cycle. It takes bits 3:0 from the value sampled at the end of the closing bit-0 cycle.
- R6: ram_we is high from bit 4 through the closing bit 0 of CPU write slots, and never in any other slot. During a write slot ram_wdata is cpu_wdata[7:4] in bits 3–5 and cpu_wdata[3:0] in bits 6, 7 and 0. It is zero in every other cycle.
- R7: vid_valid is high for exactly the closing bit-0 cycle of a video slot. vid_byte takes the new byte from the next cycle and holds it until the next video slot.
- R8: cpu_rdata takes the byte from the cycle after a CPU read slot closes. Video slots and write slots leave it unchanged.
- R9: A synchronous active-low reset clears all outputs to zero and restarts the phase ring. A slot that reset interrupts delivers no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vid_req | input | 1 | Video asks for the next slot |
| vid_inhibit | input | 1 | Forces the next slot to the CPU |
| vid_addr | input | 16 | Video byte address |
| cpu_addr | input | 16 | CPU byte address |
| cpu_rd | input | 1 | CPU direction, 1 = read, 0 = write |
| cpu_wdata | input | 8 | CPU write byte |
| ram_rdata | input | 4 | Nibble read from the DRAM |
| ram_addr | output | 9 | Multiplexed row/column address |
| row_strobe | output | 1 | Row strobe, active high |
| col_strobe | output | 1 | Column strobe, active high |
| ram_we | output | 1 | DRAM write enable, active high |
| ram_wdata | output | 4 | Nibble written to the DRAM |
| vid_valid | output | 1 | One-cycle pulse ending a video slot |
| vid_byte | output | 8 | Last byte fetched for video |
| cpu_rdata | output | 8 | Last byte read for the CPU |

## Verification
The bench walks every cycle of each slot. It compares the strobes, the bus address and the write nibble against the slot map. A design that slipped one phase, or that drove the column before the row strobe, shows up in the first slot.

Vectors mix video requests with and without inhibit, CPU writes that a video request overrides, and column and row boundary addresses such as 0x007F, 0x0080 and 0xFF80. Swapped nibbles or a dropped column bit therefore change the assembled byte.

Directed tests change every input in the middle of a slot, which catches a design that samples anything after slot start. They also reset in the middle of a video slot, which catches a design that still delivers the byte it cut off.

// File: rtl/nds_pkg.sv
// Shared constants for the nibble DRAM sequencer.
// Assumes a fixed eight-phase slot; the phase values are the one-hot codes.
package nds_pkg;
    localparam int SLOT_PH = 8;
    localparam logic [SLOT_PH-1:0] PH_START  = 8'h01; // owner sampled, row driven
    localparam logic [SLOT_PH-1:0] PH_ROW    = 8'h02; // row strobe raised
    localparam logic [SLOT_PH-1:0] PH_COL_HI = 8'h04; // first column driven
    localparam logic [SLOT_PH-1:0] PH_STB_HI = 8'h08; // first column strobe
    localparam logic [SLOT_PH-1:0] PH_HOLD   = 8'h10; // idle phase
    localparam logic [SLOT_PH-1:0] PH_RD_HI  = 8'h20; // high nibble taken
    localparam logic [SLOT_PH-1:0] PH_STB_LO = 8'h40; // second column strobe
    localparam logic [SLOT_PH-1:0] PH_LAST   = 8'h80; // video valid raised
endpackage

// File: rtl/nds_phase_ring.sv
// One-hot phase ring: rotates left once per clock.
// Assumes N >= 2; reset loads the slot-start code (bit 0).
module nds_phase_ring #(
    parameter int N = nds_pkg::SLOT_PH
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [N-1:0] phase_o
);
    // Advance the ring (R1).
    always_ff @(posedge clk) begin
        if (!rst_n) phase_o <= N'(1);
        else        phase_o <= {phase_o[N-2:0], phase_o[N-1]};
    end
endmodule

// File: rtl/nds_addr_split.sv
// Splits a byte address into a DRAM row and the two nibble column codes.
// Purely combinational; assumes ADDR_W > COL_W.
module nds_addr_split #(
    parameter int ADDR_W = 16,
    parameter int COL_W  = 7,
    localparam int ROW_W = ADDR_W - COL_W
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ROW_W-1:0]  row_o,
    output logic [COL_W:0]    col_hi_o,
    output logic [COL_W:0]    col_lo_o
);
    // Row is the upper address part; columns append the nibble select (R3, R4).
    always_comb begin
        row_o    = addr_i[ADDR_W-1:COL_W];
        col_hi_o = {addr_i[COL_W-1:0], 1'b0};
        col_lo_o = {addr_i[COL_W-1:0], 1'b1};
    end
endmodule

// File: rtl/nds_nibble_join.sv
// Joins two DRAM nibbles into a byte and hands it to video or CPU.
// Assumes cap_hi comes before cap_lo within one slot.
module nds_nibble_join #(
    parameter int NIB_W = 4,
    localparam int BYTE_W = 2 * NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_hi,
    input  logic              cap_lo,
    input  logic              to_vid,
    input  logic              to_cpu,
    input  logic [NIB_W-1:0]  nib_i,
    output logic [BYTE_W-1:0] vid_byte_o,
    output logic [BYTE_W-1:0] cpu_byte_o
);
    logic [NIB_W-1:0] hi_q;

    // Hold the high nibble from the first column access (R5).
    always_ff @(posedge clk) begin
        if (!rst_n)      hi_q <= '0;
        else if (cap_hi) hi_q <= nib_i;
    end

    // Deliver the joined byte to its owner at slot close (R5, R7, R8).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vid_byte_o <= '0;
            cpu_byte_o <= '0;
        end else if (cap_lo) begin
            if (to_vid) vid_byte_o <= {hi_q, nib_i};
            if (to_cpu) cpu_byte_o <= {hi_q, nib_i};
        end
    end
endmodule

// File: rtl/nibble_dram_seq.sv
// Nibble-wide DRAM access sequencer: one byte per eight-cycle slot,
// shared between a video fetcher and a CPU. Assumes the DRAM latches
// the address on the rising edge of each strobe.
module nibble_dram_seq #(
    parameter int ADDR_W = 16,
    parameter int COL_W  = 7,
    parameter int NIB_W  = 4,
    localparam int ROW_W  = ADDR_W - COL_W,
    localparam int RA_W   = (ROW_W > COL_W + 1) ? ROW_W : COL_W + 1,
    localparam int BYTE_W = 2 * NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vid_req,
    input  logic              vid_inhibit,
    input  logic [ADDR_W-1:0] vid_addr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic [BYTE_W-1:0] cpu_wdata,
    input  logic [NIB_W-1:0]  ram_rdata,
    output logic [RA_W-1:0]   ram_addr,
    output logic              row_strobe,
    output logic              col_strobe,
    output logic              ram_we,
    output logic [NIB_W-1:0]  ram_wdata,
    output logic              vid_valid,
    output logic [BYTE_W-1:0] vid_byte,
    output logic [BYTE_W-1:0] cpu_rdata
);
    import nds_pkg::*;

    logic [SLOT_PH-1:0] phase;
    logic               slot_live, slot_vid, slot_rd;
    logic [ADDR_W-1:0]  slot_addr;
    logic [BYTE_W-1:0]  slot_wdata;
    logic               vid_go;
    logic [ADDR_W-1:0]  split_addr;
    logic [ROW_W-1:0]   sp_row;
    logic [COL_W:0]     sp_col_hi, sp_col_lo;

    nds_phase_ring #(.N(SLOT_PH)) u_ring (
        .clk(clk), .rst_n(rst_n), .phase_o(phase)
    );

    // Pick the slot owner from the live inputs (R2).
    always_comb begin
        vid_go     = vid_req & ~vid_inhibit;
        split_addr = (phase == PH_START) ? (vid_go ? vid_addr : cpu_addr) : slot_addr;
    end

    nds_addr_split #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_split (
        .addr_i(split_addr), .row_o(sp_row),
        .col_hi_o(sp_col_hi), .col_lo_o(sp_col_lo)
    );

    // Latch the owner, address, direction and write data at slot start (R2, R9).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_live  <= 1'b0;
            slot_vid   <= 1'b0;
            slot_rd    <= 1'b1;
            slot_addr  <= '0;
            slot_wdata <= '0;
        end else if (phase == PH_START) begin
            slot_live  <= 1'b1;
            slot_vid   <= vid_go;
            slot_rd    <= vid_go | cpu_rd;
            slot_addr  <= split_addr;
            slot_wdata <= cpu_wdata;
        end
    end

    // Drive the address bus, strobes and write nibbles phase by phase (R3, R4, R6, R7).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_addr   <= '0;
            row_strobe <= 1'b0;
            col_strobe <= 1'b0;
            ram_we     <= 1'b0;
            ram_wdata  <= '0;
            vid_valid  <= 1'b0;
        end else begin
            vid_valid <= 1'b0;
            case (phase)
                PH_START: begin
                    ram_addr   <= RA_W'(sp_row);
                    row_strobe <= 1'b0;
                    col_strobe <= 1'b0;
                    ram_we     <= 1'b0;
                    ram_wdata  <= '0;
                end
                PH_ROW:    row_strobe <= 1'b1;
                PH_COL_HI: begin
                    ram_addr  <= RA_W'(sp_col_hi);
                    ram_wdata <= slot_rd ? '0 : slot_wdata[BYTE_W-1:NIB_W];
                end
                PH_STB_HI: begin
                    col_strobe <= 1'b1;
                    ram_we     <= ~slot_rd;
                end
                PH_HOLD: ;
                PH_RD_HI: begin
                    col_strobe <= 1'b0;
                    ram_addr   <= RA_W'(sp_col_lo);
                    ram_wdata  <= slot_rd ? '0 : slot_wdata[NIB_W-1:0];
                end
                PH_STB_LO: col_strobe <= 1'b1;
                PH_LAST:   vid_valid  <= slot_vid & slot_live;
                default: ;
            endcase
        end
    end

    nds_nibble_join #(.NIB_W(NIB_W)) u_join (
        .clk(clk), .rst_n(rst_n),
        .cap_hi(phase == PH_RD_HI),
        .cap_lo(phase == PH_START),
        .to_vid(slot_live & slot_vid),
        .to_cpu(slot_live & slot_rd & ~slot_vid),
        .nib_i(ram_rdata),
        .vid_byte_o(vid_byte),
        .cpu_byte_o(cpu_rdata)
    );
endmodule

// File: rtl/nds_checker.sv
// Protocol checker for the nibble DRAM sequencer, bound to the top module.
module nds_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] phase,
    input logic       row_strobe,
    input logic       col_strobe,
    input logic       ram_we,
    input logic       vid_valid,
    input logic       slot_rd
);
    a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(phase));
    a_r1_rotate: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> phase == {$past(phase[6:0]), $past(phase[7])});
    a_r3_row_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(row_strobe) |-> phase == 8'h04);
    a_r4_col_in_row: assert property (@(posedge clk) disable iff (!rst_n)
        col_strobe |-> row_strobe);
    a_r4_col_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(col_strobe) |-> (phase == 8'h10 || phase == 8'h80));
    a_r6_we_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (row_strobe && !slot_rd));
    a_r7_valid_phase: assert property (@(posedge clk) disable iff (!rst_n)
        vid_valid |-> phase == 8'h01);
    a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        vid_valid |=> !vid_valid);
endmodule

bind nibble_dram_seq nds_checker u_nds_checker (
    .clk(clk), .rst_n(rst_n), .phase(phase),
    .row_strobe(row_strobe), .col_strobe(col_strobe),
    .ram_we(ram_we), .vid_valid(vid_valid), .slot_rd(slot_rd)
);

// File: tb/nibble_dram_seq_bench.sv
`timescale 1ns/1ps
module nibble_dram_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vid_req = 1'b0, vid_inhibit = 1'b0, cpu_rd = 1'b1;
    logic [15:0] vid_addr = '0, cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [3:0]  ram_rdata;
    logic [8:0]  ram_addr;
    logic        row_strobe, col_strobe, ram_we, vid_valid;
    logic [3:0]  ram_wdata;
    logic [7:0]  vid_byte, cpu_rdata;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;
    logic [7:0] exp_vb = '0, exp_cpu = '0;
    logic [8:0] lat_row = '0;
    logic       row_prev = 1'b0;

    always #2 clk = ~clk;

    nibble_dram_seq u_nibble_dram_seq (
        .clk(clk), .rst_n(rst_n), .vid_req(vid_req), .vid_inhibit(vid_inhibit),
        .vid_addr(vid_addr), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .cpu_wdata(cpu_wdata), .ram_rdata(ram_rdata), .ram_addr(ram_addr),
        .row_strobe(row_strobe), .col_strobe(col_strobe), .ram_we(ram_we),
        .ram_wdata(ram_wdata), .vid_valid(vid_valid), .vid_byte(vid_byte),
        .cpu_rdata(cpu_rdata)
    );

    function automatic logic [7:0] byte_of(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic logic [3:0] nib_of(input logic [8:0] r, input logic [8:0] c);
        logic [7:0] b;
        b = byte_of({r, c[7:1]});
        return c[0] ? b[3:0] : b[7:4];
    endfunction

    // DRAM model: latch the row on the rising row strobe, return a pattern nibble.
    assign ram_rdata = nib_of(lat_row, ram_addr);
    always @(negedge clk) begin
        if (row_strobe && !row_prev) lat_row <= ram_addr;
        row_prev <= row_strobe;
    end

    task automatic check(input string req, input logic ok,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    // Runs one slot from a negedge just before its start edge.
    task automatic do_slot(input logic vr, input logic vi, input logic rd,
                           input logic [15:0] va, input logic [15:0] ca,
                           input logic [7:0] wd, input logic midchange);
        logic go, wr;
        logic [15:0] a;
        logic [31:0] a3, e3, a4, e4, a6, e6, a7, e7;
        logic b3, b4, b6, b7;
        logic [8:0] ex_addr;
        logic [3:0] ex_wd;
        go = vr & ~vi;
        wr = !go && !rd;
        a  = go ? va : ca;
        vid_req = vr; vid_inhibit = vi; cpu_rd = rd;
        vid_addr = va; cpu_addr = ca; cpu_wdata = wd;
        b3 = 0; b4 = 0; b6 = 0; b7 = 0;
        a3 = 0; e3 = 0; a4 = 0; e4 = 0; a6 = 0; e6 = 0; a7 = 0; e7 = 0;
        for (int k = 0; k < 8; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k == 0) begin
                check("R5 R7 vid_byte", vid_byte === exp_vb, vid_byte, exp_vb);
                check("R5 R8 cpu_rdata", cpu_rdata === exp_cpu, cpu_rdata, exp_cpu);
                if (midchange) begin
                    vid_req = ~vr; vid_inhibit = ~vi; cpu_rd = ~rd;
                    vid_addr = ~va; cpu_addr = ~ca; cpu_wdata = ~wd;
                end
            end
            ex_addr = (k <= 1) ? 9'(a[15:7]) : (k <= 4) ? {1'b0, a[6:0], 1'b0}
                                                          : {1'b0, a[6:0], 1'b1};
            ex_wd = (!wr || k <= 1) ? 4'h0 : (k <= 4) ? wd[7:4] : wd[3:0];
            if (!b3 && {row_strobe, ram_addr} !== {(k >= 1), ex_addr}) begin
                b3 = 1; a3 = {k, 3'b0, row_strobe, 3'b0, ram_addr};
                e3 = {k, 3'b0, (k >= 1), 3'b0, ex_addr};
            end
            if (!b4 && col_strobe !== (k == 3 || k == 4 || k == 6 || k == 7)) begin
                b4 = 1; a4 = {k, 3'b0, col_strobe};
                e4 = {k, 3'b0, (k == 3 || k == 4 || k == 6 || k == 7)};
            end
            if (!b6 && {ram_we, ram_wdata} !== {(wr && k >= 3), ex_wd}) begin
                b6 = 1; a6 = {k, 3'b0, ram_we, ram_wdata};
                e6 = {k, 3'b0, (wr && k >= 3), ex_wd};
            end
            if (!b7 && vid_valid !== (go && k == 7)) begin
                b7 = 1; a7 = {k, 3'b0, vid_valid}; e7 = {k, 3'b0, (go && k == 7)};
            end
        end
        check(midchange ? "R2 R3 row phase" : "R3 row phase", !b3, a3, e3);
        check("R1 R4 column phase", !b4, a4, e4);
        check(midchange ? "R2 R6 write" : "R6 write", !b6, a6, e6);
        check(vi ? "R2 R7 vid_valid" : "R7 vid_valid", !b7, a7, e7);
        if (go)      exp_vb  = byte_of(va);
        else if (rd) exp_cpu = byte_of(ca);
    endtask

    // {vid_req, vid_inhibit, cpu_rd, vid_addr, cpu_addr, cpu_wdata}
    localparam int NV = 11;
    localparam logic [42:0] VEC [NV] = '{
        {1'b1, 1'b0, 1'b1, 16'h5800, 16'h1234, 8'h00},
        {1'b0, 1'b0, 1'b1, 16'h0000, 16'h1234, 8'h00},
        {1'b1, 1'b1, 1'b1, 16'h7FFF, 16'hABCD, 8'h00},
        {1'b0, 1'b0, 1'b0, 16'h0000, 16'h3C81, 8'hA5},
        {1'b1, 1'b0, 1'b1, 16'hFFFF, 16'h0000, 8'h00},
        {1'b1, 1'b0, 1'b0, 16'h2222, 16'h0001, 8'h5A},
        {1'b1, 1'b1, 1'b0, 16'h1111, 16'h007F, 8'hF0},
        {1'b0, 1'b0, 1'b1, 16'h0000, 16'h0080, 8'h00},
        {1'b1, 1'b0, 1'b1, 16'h0000, 16'h9999, 8'h00},
        {1'b0, 1'b0, 1'b0, 16'h0000, 16'hFF80, 8'h0F},
        {1'b0, 1'b0, 1'b1, 16'h0000, 16'h0000, 8'h00}
    };

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000 && !done) begin
            n_fail++;
            $display("FAIL R1 watchdog: actual %0d expected %0d", cyc, 0);
            summary();
            $finish;
        end
    end

    initial begin
        // R9: reset state.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 reset bus", {row_strobe, col_strobe, ram_we, vid_valid, ram_addr, ram_wdata} === '0,
              {row_strobe, col_strobe, ram_we, vid_valid, ram_addr, ram_wdata}, 0);
        check("R9 reset bytes", {vid_byte, cpu_rdata} === '0, {vid_byte, cpu_rdata}, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++)
            do_slot(VEC[i][42], VEC[i][41], VEC[i][40], VEC[i][39:24],
                    VEC[i][23:8], VEC[i][7:0], 1'b0);

        // R2: inputs flipped mid-slot must not affect it.
        do_slot(1'b0, 1'b0, 1'b1, 16'h0000, 16'h6C35, 8'h00, 1'b1);
        do_slot(1'b1, 1'b1, 1'b0, 16'h4444, 16'h0123, 8'hC3, 1'b1);
        do_slot(1'b1, 1'b0, 1'b1, 16'h3A7E, 16'h0000, 8'h00, 1'b1);

        // R9: reset in the middle of a video slot delivers nothing.
        vid_req = 1'b1; vid_inhibit = 1'b0; vid_addr = 16'h4321;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R9 mid-slot reset bus", {row_strobe, col_strobe, ram_we, vid_valid} === '0,
              {row_strobe, col_strobe, ram_we, vid_valid}, 0);
        check("R9 mid-slot reset bytes", {vid_byte, cpu_rdata} === '0, {vid_byte, cpu_rdata}, 0);
        exp_vb = '0; exp_cpu = '0;
        rst_n = 1'b1;
        do_slot(1'b0, 1'b0, 1'b1, 16'h0000, 16'h2468, 8'h00, 1'b0);
        do_slot(1'b0, 1'b0, 1'b1, 16'h0000, 16'h0000, 8'h00, 1'b0);

        done = 1;
        summary();
        $finish;
    end
endmodule